// File: doc/BRIEF.md
# Power-Management Bus Command Channel Engine

This block gives a host processor a small memory-mapped window through which it runs one read or write transaction at a time on a two-wire power-management bus. The host first loads up to eight bytes into two write-data words, sets its own execution-environment number in the config word, and then writes a command word. That command word carries the opcode, slave ID, register address and byte count together. The engine checks that the target peripheral belongs to the host's execution environment and then hands the transaction to a back-end serializer through a request/acknowledge handshake.

The host learns the outcome by polling a status word. It holds four flags: finished, failed, denied and dropped. The three error flags are only meaningful while the finished flag is set. When a read completes cleanly, the returned bytes appear little-endian in two read-data words. Any byte past the requested count reads as zero. The serializer itself lives outside this block.

Top module: `cmd_chan_engine`

## Requirements
- R1: After reset the status word, the config word, both read-data words and `be_req` are all zero.
- R2: Writing the command word (offset 0x00) while idle with access granted raises `be_req` on the next clock edge. The back-end fields are then decoded from the command word as follows: opcode from bits 31:27, slave ID from bits 23:20, address from bits 19:4, and byte count minus one from bits 2:0. The status word reads zero while the transaction runs.
- R3: `be_wdata` is the write data packed little-endian: byte 0 sits in bits 7:0 of the word at 0x10, and byte 4 sits in bits 7:0 of the word at 0x14. Every byte above the command's byte count is driven as zero.
- R4: A cycle with `be_ack` high while requesting ends the transaction. `be_req` falls on that edge and status becomes 0x1. Status bits are: bit 0 finished, bit 1 failed, bit 2 denied, bit 3 dropped.
- R5: When a read opcode completes with an acknowledge, the read-data words (0x18 for bytes 0 to 3, 0x1C for bytes 4 to 7) take the returned bytes, and bytes above the byte count become zero. The read opcodes are 1, 8, 13 and 15. Any other opcode leaves the read-data words unchanged.
- R6: A cycle with `be_nack` high while requesting ends the transaction with status 0x3 and leaves the read-data words unchanged.
- R7: The owner of the peripheral given by address bits 15:8 is the 3-bit field `owner_map[3i+2:3i]`, where i is the peripheral number. If that owner differs from config bits 2:0, or if the peripheral number is at or above the table size, status becomes 0x5 one edge after the command write and `be_req` stays low.
- R8: A command written while a transaction runs is ignored, so the back-end fields keep their values. The running transaction then ends with the dropped flag added, for example status 0x9 after an acknowledge.
- R9: Writes to the write-data words while a transaction runs are ignored. Both `be_wdata` and the readback keep their values.
- R10: The registers read back at these offsets: 0x00 returns the last accepted command, 0x04 the config, 0x08 the status, 0x10 and 0x14 the write data, and 0x18 and 0x1C the read data. Any other offset reads zero.
- R11: `be_req` stays high, with stable fields, until `be_ack` or `be_nack` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 5 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` (combinational) |
| owner_map | input | 48 | Owner field for each peripheral, 3 bits per peripheral |
| be_req | output | 1 | Back-end transaction request |
| be_opcode | output | 5 | Back-end opcode |
| be_sid | output | 4 | Back-end slave ID |
| be_addr | output | 16 | Back-end register address |
| be_bcnt | output | 3 | Back-end byte count minus one |
| be_wdata | output | 64 | Packed write data with unused bytes zeroed |
| be_ack | input | 1 | Back-end completion, success |
| be_nack | input | 1 | Back-end completion, failure |
| be_rdata | input | 64 | Back-end returned bytes |

## Verification
The reset synchronizer holds the engine in reset for two cycles, so the bench waits five cycles after reset is released before it drives anything. Every register write and every back-end response is held across exactly one rising edge and removed at the following falling edge.

Each result is due on a fixed edge:
- `be_req`, the decoded fields, the packed write data and the zero busy status appear on the edge that captures the command write.
- A denial shows up as status 0x5 on that same edge.
- The finished, failed and dropped flags, and the read-data words, change on the edge that captures `be_ack` or `be_nack`.

The bench therefore samples all outputs and readback at the falling edge just after the edge concerned. For the ignored writes it reads the registers back through the host port before any further stimulus is applied.

// File: rtl/cmd_chan_pkg.sv
package cmd_chan_pkg;

  localparam int OPC_W  = 5;
  localparam int SID_W  = 4;
  localparam int ADR_W  = 16;
  localparam int BC_W   = 3;
  localparam int NBYTES = 8;
  localparam int OWN_W  = 3;
  localparam int STS_W  = 4;
  localparam int WORD_W = 32;

  // bit positions inside the command word
  localparam int OPC_LSB = 27;
  localparam int SID_LSB = 20;
  localparam int ADR_LSB = 4;
  localparam int BC_LSB  = 0;

  // status bit indices
  localparam int ST_DONE = 0;
  localparam int ST_FAIL = 1;
  localparam int ST_DENY = 2;
  localparam int ST_DROP = 3;

  // register byte offsets
  localparam logic [4:0] OFS_CMD = 5'h00;
  localparam logic [4:0] OFS_CFG = 5'h04;
  localparam logic [4:0] OFS_STS = 5'h08;
  localparam logic [4:0] OFS_WD0 = 5'h10;
  localparam logic [4:0] OFS_WD1 = 5'h14;
  localparam logic [4:0] OFS_RD0 = 5'h18;
  localparam logic [4:0] OFS_RD1 = 5'h1C;

  typedef enum logic [OPC_W-1:0] {
    OP_XL_WR = 5'd0,
    OP_XL_RD = 5'd1,
    OP_X_WR  = 5'd2,
    OP_RST   = 5'd3,
    OP_SLP   = 5'd4,
    OP_SHDN  = 5'd5,
    OP_WAKE  = 5'd6,
    OP_AUTH  = 5'd7,
    OP_M_RD  = 5'd8,
    OP_M_WR  = 5'd9,
    OP_X_RD  = 5'd13,
    OP_WR    = 5'd14,
    OP_RD    = 5'd15,
    OP_ZWR   = 5'd16
  } opc_e;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [SID_W-1:0] sid;
    logic [ADR_W-1:0] adr;
    logic [BC_W-1:0]  bc;
  } cmd_t;

  typedef enum logic {S_IDLE = 1'b0, S_BUSY = 1'b1} st_e;

  function automatic cmd_t unpack_cmd(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.opc = w[OPC_LSB +: OPC_W];
    c.sid = w[SID_LSB +: SID_W];
    c.adr = w[ADR_LSB +: ADR_W];
    c.bc  = w[BC_LSB  +: BC_W];
    return c;
  endfunction

  function automatic logic is_read_op(input logic [OPC_W-1:0] op);
    return (op == OP_XL_RD) || (op == OP_M_RD) ||
           (op == OP_X_RD)  || (op == OP_RD);
  endfunction

endpackage

// File: rtl/cmd_owner_check.sv
module cmd_owner_check #(
  parameter int NUM_PERIPH = 16,
  parameter int OWN_W      = 3,
  parameter int PER_W      = 8
) (
  input  logic [PER_W-1:0]            periph,
  input  logic [OWN_W-1:0]            ee,
  input  logic [NUM_PERIPH*OWN_W-1:0] owner_map,
  output logic                        granted
);

  logic [NUM_PERIPH-1:0] hit;

  // one comparator per table entry; an index past the table never hits
  generate
    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_ent
      assign hit[i] = (periph == PER_W'(i)) &&
                      (owner_map[i*OWN_W +: OWN_W] == ee);
    end
  endgenerate

  assign granted = |hit;

endmodule

// File: rtl/cmd_byte_mask.sv
module cmd_byte_mask #(
  parameter int NBYTES = 8,
  parameter int BC_W   = 3
) (
  input  logic [BC_W-1:0]     last,
  input  logic [8*NBYTES-1:0] din,
  output logic [8*NBYTES-1:0] dout
);

  // byte lane i passes only when i <= last (count minus one)
  generate
    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      assign dout[8*i +: 8] = (i <= int'(last)) ? din[8*i +: 8] : 8'h00;
    end
  endgenerate

endmodule

// File: rtl/cmd_chan_regs.sv
module cmd_chan_regs
  import cmd_chan_pkg::*;
#(
  parameter int CSR_AW = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csr_wr,
  input  logic [CSR_AW-1:0]   csr_addr,
  input  logic [WORD_W-1:0]   csr_wdata,
  output logic [WORD_W-1:0]   csr_rdata,
  input  logic                busy,
  input  logic                cmd_accept,
  input  logic                rd_load,
  input  logic [8*NBYTES-1:0] rd_word,
  input  logic [STS_W-1:0]    sts,
  output logic                cmd_wr,
  output logic [WORD_W-1:0]   cmd_word,
  output logic [OWN_W-1:0]    ee,
  output logic [8*NBYTES-1:0] wr_word
);

  localparam int HALF = 4 * NBYTES;

  logic [WORD_W-1:0] cmd_q, wd0_q, wd1_q, rd0_q, rd1_q;
  logic [OWN_W-1:0]  cfg_q;
  logic              cfg_en, wd0_en, wd1_en;

  // write decode; data words are locked while a transaction runs
  always_comb begin
    cmd_wr = csr_wr && (csr_addr == CSR_AW'(OFS_CMD));
    cfg_en = csr_wr && (csr_addr == CSR_AW'(OFS_CFG));
    wd0_en = csr_wr && (csr_addr == CSR_AW'(OFS_WD0)) && !busy;
    wd1_en = csr_wr && (csr_addr == CSR_AW'(OFS_WD1)) && !busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      cfg_q <= '0;
      wd0_q <= '0;
      wd1_q <= '0;
      rd0_q <= '0;
      rd1_q <= '0;
    end else begin
      if (cmd_accept) cmd_q <= csr_wdata;
      if (cfg_en)     cfg_q <= csr_wdata[OWN_W-1:0];
      if (wd0_en)     wd0_q <= csr_wdata;
      if (wd1_en)     wd1_q <= csr_wdata;
      if (rd_load) begin
        rd0_q <= rd_word[HALF-1:0];
        rd1_q <= rd_word[2*HALF-1:HALF];
      end
    end
  end

  always_comb begin
    case (csr_addr)
      CSR_AW'(OFS_CMD): csr_rdata = cmd_q;
      CSR_AW'(OFS_CFG): csr_rdata = WORD_W'(cfg_q);
      CSR_AW'(OFS_STS): csr_rdata = WORD_W'(sts);
      CSR_AW'(OFS_WD0): csr_rdata = wd0_q;
      CSR_AW'(OFS_WD1): csr_rdata = wd1_q;
      CSR_AW'(OFS_RD0): csr_rdata = rd0_q;
      CSR_AW'(OFS_RD1): csr_rdata = rd1_q;
      default:          csr_rdata = '0;
    endcase
  end

  assign cmd_word = cmd_q;
  assign ee       = cfg_q;
  assign wr_word  = {wd1_q, wd0_q};

endmodule

// File: rtl/cmd_chan_seq.sv
module cmd_chan_seq
  import cmd_chan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic             granted,
  input  logic             cur_is_read,
  input  logic             be_ack,
  input  logic             be_nack,
  output logic             busy,
  output logic             cmd_accept,
  output logic             rd_load,
  output logic [STS_W-1:0] sts
);

  st_e              state_q, state_d;
  logic [STS_W-1:0] sts_q, sts_d;
  logic             drop_q, drop_d, drop_now;

  always_comb begin
    state_d    = state_q;
    sts_d      = sts_q;
    drop_d     = drop_q;
    drop_now   = drop_q;
    cmd_accept = 1'b0;
    rd_load    = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (cmd_wr) begin
          cmd_accept = 1'b1;
          drop_d     = 1'b0;
          sts_d      = '0;
          if (granted) begin
            state_d = S_BUSY;
          end else begin
            sts_d[ST_DONE] = 1'b1;
            sts_d[ST_DENY] = 1'b1;
          end
        end
      end
      S_BUSY: begin
        drop_now = drop_q | cmd_wr;
        drop_d   = drop_now;
        if (be_nack) begin
          state_d        = S_IDLE;
          drop_d         = 1'b0;
          sts_d          = '0;
          sts_d[ST_DONE] = 1'b1;
          sts_d[ST_FAIL] = 1'b1;
          sts_d[ST_DROP] = drop_now;
        end else if (be_ack) begin
          state_d        = S_IDLE;
          drop_d         = 1'b0;
          sts_d          = '0;
          sts_d[ST_DONE] = 1'b1;
          sts_d[ST_DROP] = drop_now;
          rd_load        = cur_is_read;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sts_q   <= '0;
      drop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sts_q   <= sts_d;
      drop_q  <= drop_d;
    end
  end

  assign busy = (state_q == S_BUSY);
  assign sts  = sts_q;

endmodule

// File: rtl/cmd_chan_engine.sv
module cmd_chan_engine
  import cmd_chan_pkg::*;
#(
  parameter int NUM_PERIPH = 16,
  parameter int CSR_AW     = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        csr_wr,
  input  logic [CSR_AW-1:0]           csr_addr,
  input  logic [WORD_W-1:0]           csr_wdata,
  output logic [WORD_W-1:0]           csr_rdata,
  input  logic [NUM_PERIPH*OWN_W-1:0] owner_map,
  output logic                        be_req,
  output logic [OPC_W-1:0]            be_opcode,
  output logic [SID_W-1:0]            be_sid,
  output logic [ADR_W-1:0]            be_addr,
  output logic [BC_W-1:0]             be_bcnt,
  output logic [8*NBYTES-1:0]         be_wdata,
  input  logic                        be_ack,
  input  logic                        be_nack,
  input  logic [8*NBYTES-1:0]         be_rdata
);

  localparam int PER_W   = 8;
  localparam int PER_LSB = ADR_LSB + ADR_W - PER_W;

  logic [1:0]          rst_pipe;
  logic                rst_sync_n;
  logic                cmd_wr, cmd_accept, busy, rd_load, granted;
  logic [STS_W-1:0]    sts_w;
  logic [WORD_W-1:0]   cmd_word;
  logic [OWN_W-1:0]    ee;
  logic [8*NBYTES-1:0] wr_word, rd_word;
  cmd_t                cur;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cmd_chan_regs #(.CSR_AW(CSR_AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .csr_wr     (csr_wr),
    .csr_addr   (csr_addr),
    .csr_wdata  (csr_wdata),
    .csr_rdata  (csr_rdata),
    .busy       (busy),
    .cmd_accept (cmd_accept),
    .rd_load    (rd_load),
    .rd_word    (rd_word),
    .sts        (sts_w),
    .cmd_wr     (cmd_wr),
    .cmd_word   (cmd_word),
    .ee         (ee),
    .wr_word    (wr_word)
  );

  // ownership is judged on the incoming command word's peripheral field
  cmd_owner_check #(.NUM_PERIPH(NUM_PERIPH), .OWN_W(OWN_W), .PER_W(PER_W)) u_own (
    .periph    (csr_wdata[PER_LSB +: PER_W]),
    .ee        (ee),
    .owner_map (owner_map),
    .granted   (granted)
  );

  assign cur = unpack_cmd(cmd_word);

  cmd_chan_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cmd_wr      (cmd_wr),
    .granted     (granted),
    .cur_is_read (is_read_op(cur.opc)),
    .be_ack      (be_ack),
    .be_nack     (be_nack),
    .busy        (busy),
    .cmd_accept  (cmd_accept),
    .rd_load     (rd_load),
    .sts         (sts_w)
  );

  cmd_byte_mask #(.NBYTES(NBYTES), .BC_W(BC_W)) u_wmask (
    .last (cur.bc),
    .din  (wr_word),
    .dout (be_wdata)
  );

  cmd_byte_mask #(.NBYTES(NBYTES), .BC_W(BC_W)) u_rmask (
    .last (cur.bc),
    .din  (be_rdata),
    .dout (rd_word)
  );

  assign be_req    = busy;
  assign be_opcode = cur.opc;
  assign be_sid    = cur.sid;
  assign be_addr   = cur.adr;
  assign be_bcnt   = cur.bc;

endmodule

// File: rtl/cmd_chan_engine_chk.sv
module cmd_chan_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        be_req,
  input logic        be_ack,
  input logic        be_nack,
  input logic [4:0]  be_opcode,
  input logic [15:0] be_addr,
  input logic [63:0] be_wdata,
  input logic [3:0]  sts
);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && !be_ack && !be_nack) |=> be_req);

  p_fields_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && !be_ack && !be_nack) |=> ($stable(be_opcode) && $stable(be_addr)));

  p_wdata_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && !be_ack && !be_nack) |=> $stable(be_wdata));

  p_busy_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    be_req |-> (sts == 4'h0));

  p_ack_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && be_ack && !be_nack) |=> (sts[0] && !sts[1] && !be_req));

  p_nack_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && be_nack) |=> (sts[0] && sts[1] && !be_req));

  p_deny_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sts[2] |-> (sts[0] && !be_req));

endmodule

bind cmd_chan_engine cmd_chan_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .be_req    (be_req),
  .be_ack    (be_ack),
  .be_nack   (be_nack),
  .be_opcode (be_opcode),
  .be_addr   (be_addr),
  .be_wdata  (be_wdata),
  .sts       (sts_w)
);

// File: tb/cmd_chan_engine_bench.sv
module cmd_chan_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0;
  logic [4:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [47:0] owner_map;
  logic        be_req;
  logic [4:0]  be_opcode;
  logic [3:0]  be_sid;
  logic [15:0] be_addr;
  logic [2:0]  be_bcnt;
  logic [63:0] be_wdata;
  logic        be_ack = 1'b0;
  logic        be_nack = 1'b0;
  logic [63:0] be_rdata = '0;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cmd_chan_engine u_cmd_chan_engine (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .owner_map(owner_map),
    .be_req(be_req), .be_opcode(be_opcode), .be_sid(be_sid), .be_addr(be_addr),
    .be_bcnt(be_bcnt), .be_wdata(be_wdata), .be_ack(be_ack), .be_nack(be_nack),
    .be_rdata(be_rdata)
  );

  function automatic logic [31:0] mkcmd(input logic [4:0] op, input logic [3:0] sid,
                                        input logic [15:0] a, input logic [2:0] bc);
    return {op, 3'b000, sid, a, 1'b0, bc};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(posedge clk);
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  task automatic respond(input logic ok, input logic [63:0] data);
    @(negedge clk);
    be_ack = ok; be_nack = !ok; be_rdata = data;
    @(posedge clk);
    @(negedge clk);
    be_ack = 1'b0; be_nack = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 be_req", 64'(be_req), 64'd0);
    rd(5'h08, v); chk("R1 status", 64'(v), 64'd0);
    rd(5'h04, v); chk("R1 config", 64'(v), 64'd0);
    rd(5'h18, v); chk("R1 rdata0", 64'(v), 64'd0);
    rd(5'h1C, v); chk("R1 rdata1", 64'(v), 64'd0);
  endtask

  task automatic t_write6;
    logic [31:0] v;
    wr(5'h04, 32'h0000_0002);
    rd(5'h04, v); chk("R10 config readback", 64'(v), 64'd2);
    wr(5'h10, 32'h4433_2211);
    wr(5'h14, 32'h8877_6655);
    wr(5'h00, mkcmd(5'd14, 4'd5, 16'h0512, 3'd5));
    chk("R2 be_req", 64'(be_req), 64'd1);
    chk("R2 opcode", 64'(be_opcode), 64'd14);
    chk("R2 sid", 64'(be_sid), 64'd5);
    chk("R2 addr", 64'(be_addr), 64'h0512);
    chk("R2 bcnt", 64'(be_bcnt), 64'd5);
    rd(5'h08, v); chk("R2 status while busy", 64'(v), 64'd0);
    chk("R3 packed 6 bytes", be_wdata, 64'h0000_6655_4433_2211);
    wr(5'h10, 32'hFFFF_FFFF);
    chk("R9 be_wdata kept", be_wdata, 64'h0000_6655_4433_2211);
    rd(5'h10, v); chk("R9 wdata0 readback kept", 64'(v), 64'h4433_2211);
    repeat (3) @(negedge clk);
    chk("R11 be_req held", 64'(be_req), 64'd1);
    respond(1'b1, 64'hDEAD_BEEF_DEAD_BEEF);
    chk("R4 be_req low", 64'(be_req), 64'd0);
    rd(5'h08, v); chk("R4 status done", 64'(v), 64'h1);
    rd(5'h18, v); chk("R5 write leaves rdata0", 64'(v), 64'd0);
  endtask

  task automatic t_reads;
    logic [31:0] v;
    wr(5'h00, mkcmd(5'd15, 4'd1, 16'h0A30, 3'd2));
    respond(1'b1, 64'hFFEE_DDCC_BBAA_9988);
    rd(5'h18, v); chk("R5 3-byte rdata0", 64'(v), 64'h00AA_9988);
    rd(5'h1C, v); chk("R5 3-byte rdata1", 64'(v), 64'd0);
    wr(5'h00, mkcmd(5'd1, 4'd2, 16'h0140, 3'd7));
    respond(1'b1, 64'h0123_4567_89AB_CDEF);
    rd(5'h18, v); chk("R5 8-byte rdata0", 64'(v), 64'h89AB_CDEF);
    rd(5'h1C, v); chk("R5 8-byte rdata1", 64'(v), 64'h0123_4567);
    wr(5'h00, mkcmd(5'd13, 4'd3, 16'h0200, 3'd4));
    respond(1'b1, 64'hA1A2_A3A4_A5A6_A7A8);
    rd(5'h18, v); chk("R5 5-byte rdata0", 64'(v), 64'hA5A6_A7A8);
    rd(5'h1C, v); chk("R5 5-byte rdata1", 64'(v), 64'h0000_00A4);
    rd(5'h08, v); chk("R4 read status", 64'(v), 64'h1);
  endtask

  task automatic t_nack;
    logic [31:0] v;
    wr(5'h00, mkcmd(5'd15, 4'd0, 16'h0400, 3'd7));
    respond(1'b0, 64'h1111_2222_3333_4444);
    rd(5'h08, v); chk("R6 status fail", 64'(v), 64'h3);
    rd(5'h18, v); chk("R6 rdata0 unchanged", 64'(v), 64'hA5A6_A7A8);
    chk("R6 be_req low", 64'(be_req), 64'd0);
  endtask

  task automatic t_deny;
    logic [31:0] v;
    wr(5'h00, mkcmd(5'd14, 4'd0, 16'h0310, 3'd0));
    chk("R7 no request", 64'(be_req), 64'd0);
    rd(5'h08, v); chk("R7 status denied", 64'(v), 64'h5);
    wr(5'h00, mkcmd(5'd15, 4'd0, 16'h2000, 3'd0));
    chk("R7 out-of-range no request", 64'(be_req), 64'd0);
    rd(5'h08, v); chk("R7 out-of-range denied", 64'(v), 64'h5);
  endtask

  task automatic t_drop;
    logic [31:0] v;
    logic [31:0] first;
    first = mkcmd(5'd14, 4'd7, 16'h0700, 3'd0);
    wr(5'h10, 32'hDEAD_BEAB);
    wr(5'h00, first);
    chk("R3 single byte packed", be_wdata, 64'h0000_0000_0000_00AB);
    wr(5'h00, mkcmd(5'd2, 4'd1, 16'h0800, 3'd3));
    chk("R8 addr kept", 64'(be_addr), 64'h0700);
    chk("R8 opcode kept", 64'(be_opcode), 64'd14);
    rd(5'h00, v); chk("R10 cmd readback is first", 64'(v), 64'(first));
    respond(1'b1, 64'd0);
    rd(5'h08, v); chk("R8 status done+dropped", 64'(v), 64'h9);
    rd(5'h0C, v); chk("R10 unmapped reads zero", 64'(v), 64'd0);
    rd(5'h14, v); chk("R10 wdata1 readback", 64'(v), 64'h8877_6655);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) owner_map[i*3 +: 3] = (i == 3) ? 3'd5 : 3'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_write6;
    t_reads;
    t_nack;
    t_deny;
    t_drop;
    summary;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary;
    $finish;
  end

endmodule